// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the shared program counter and the per-lane active mask of one warp. All lanes run under one PC, but each lane can resolve a conditional branch its own way. When the lanes that are currently active disagree, the block runs the two sides one after the other, never together. The taken side runs first. The fall-through side waits on a small hardware stack with the lanes it owns.

Each divergent branch pushes two entries. The lower entry is a reconvergence entry: it holds the reconvergence address and the mask the warp had before the branch. The upper entry holds the fall-through address and the lanes that did not take the branch. A pulse on `reconv_hit` means the running path has reached its reconvergence point, and it pops the top entry. The first pop starts the fall-through side. The second pop restores the full mask at the reconvergence address. If every active lane agrees, the branch only moves the PC. Divergence nests up to the stack depth.

Branch events arrive on a valid/ready channel. `br_ready` is high in every cycle except one in which `reconv_hit` is asserted. A branch is accepted on a cycle where both `br_valid` and `br_ready` are high. A branch offered while `br_ready` is low is not taken in, and the source must hold it and offer it again.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `cur_pc` equals the RESET_PC parameter, `active_mask` is all ones, `stack_empty` is 1 and `stack_overflow` is 0.
- R2: If every active lane is set in an accepted branch's taken mask, the next cycle shows `cur_pc` = `br_target`. The mask and the stack depth do not change.
- R3: If no active lane is set in the taken mask, the next cycle shows `cur_pc` = `br_fallthru`. The mask and the stack depth do not change.
- R4: Taken-mask bits of inactive lanes are ignored. Bit i of a mask belongs to lane i.
- R5: A divergent branch with at least two free slots pushes two entries. The next cycle shows `cur_pc` = `br_target` and `active_mask` = old mask AND taken mask.
- R6: The first `reconv_hit` after a divergent branch sets `cur_pc` = `br_fallthru` and `active_mask` = old mask AND NOT taken mask.
- R7: The second `reconv_hit` sets `cur_pc` = `br_reconv` and `active_mask` = the mask from before the branch.
- R8: Nested divergences unwind in last-in, first-out order.
- R9: A divergent branch with fewer than two free slots leaves the PC, the mask and the stack unchanged. It sets `stack_overflow`, which stays set until reset.
- R10: `reconv_hit` while the stack is empty has no effect.
- R11: `br_ready` is 0 whenever `reconv_hit` is 1. A branch offered in that cycle is not accepted, and only the pop happens.
- R12: `stack_empty` is 1 exactly when the stack holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch event is offered |
| br_ready | output | 1 | A branch event can be accepted this cycle |
| br_taken_mask | input | LANES | Per-lane branch outcome, 1 = taken |
| br_target | input | PC_W | Taken address |
| br_fallthru | input | PC_W | Fall-through address |
| br_reconv | input | PC_W | Reconvergence address |
| reconv_hit | input | 1 | The running path has reached its reconvergence point |
| cur_pc | output | PC_W | Current warp PC |
| active_mask | output | LANES | Current active lanes |
| stack_empty | output | 1 | No entries are stacked |
| stack_overflow | output | 1 | Sticky: a push was refused because the stack was full |

## Verification
The assertions assume the warp's active mask is never all zero. A pop only happens on a cycle with no accepted branch, which the ready rule guarantees. The stimulus starts every branch from a mask built by earlier branches of the sweep, and that mask always has at least one lane set. It issues pops only as `reconv_hit` pulses. Collision cycles, with a branch and a pop together, are driven on purpose to exercise the ready rule. The overflow sequence picks nested taken masks that each leave at least two lanes active, so that each inner branch can still diverge.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [1:0] {
    BR_ALL_TAKEN = 2'd0,
    BR_ALL_FALL  = 2'd1,
    BR_SPLIT     = 2'd2
  } br_kind_e;
endpackage

// File: rtl/simt_branch_classify.sv
module simt_branch_classify
  import simt_stack_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] live_mask,
  input  logic [LANES-1:0] taken_raw,
  output logic [LANES-1:0] taken_live,
  output logic [LANES-1:0] fall_live,
  output br_kind_e         kind
);
  // Only live lanes vote; the rest are masked out here.
  always_comb begin
    taken_live = live_mask & taken_raw;
    fall_live  = live_mask & ~taken_raw;
    if (taken_live == '0)     kind = BR_ALL_FALL;
    else if (fall_live == '0) kind = BR_ALL_TAKEN;
    else                      kind = BR_SPLIT;
  end
endmodule

// File: rtl/simt_entry_lifo.sv
module simt_entry_lifo #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push2,
  input  logic             pop,
  input  logic [PC_W-1:0]  lo_pc,
  input  logic [LANES-1:0] lo_mask,
  input  logic [PC_W-1:0]  hi_pc,
  input  logic [LANES-1:0] hi_mask,
  output logic [PC_W-1:0]  top_pc,
  output logic [LANES-1:0] top_mask,
  output logic [CNT_W-1:0] fill
);
  logic [PC_W-1:0]  slot_pc   [DEPTH];
  logic [LANES-1:0] slot_mask [DEPTH];
  logic [IDX_W-1:0] wr_lo, wr_hi, rd_top;

  assign wr_lo  = IDX_W'(fill);
  assign wr_hi  = wr_lo + IDX_W'(1);
  assign rd_top = wr_lo - IDX_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_pc[g]   <= '0;
        slot_mask[g] <= '0;
      end else if (push2 && wr_lo == IDX_W'(g)) begin
        slot_pc[g]   <= lo_pc;
        slot_mask[g] <= lo_mask;
      end else if (push2 && wr_hi == IDX_W'(g)) begin
        slot_pc[g]   <= hi_pc;
        slot_mask[g] <= hi_mask;
      end
    end
  end

  assign top_pc   = slot_pc[rd_top];
  assign top_mask = slot_mask[rd_top];

  always_ff @(posedge clk) begin
    if (!rst_n)     fill <= '0;
    else if (push2) fill <= fill + CNT_W'(2);
    else if (pop)   fill <= fill - CNT_W'(1);
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)); // R9
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push2 |=> fill == $past(fill) + CNT_W'(2)); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push2) |=> fill == $past(fill) - CNT_W'(1)); // R8
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [LANES-1:0] br_taken_mask,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic             reconv_hit,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] active_mask,
  output logic             stack_empty,
  output logic             stack_overflow
);
  logic [LANES-1:0] taken_live, fall_live, top_mask;
  logic [PC_W-1:0]  top_pc;
  logic [CNT_W-1:0] fill;
  br_kind_e         kind;
  logic             br_fire, do_pop, has_room, do_push, refuse;

  simt_branch_classify #(.LANES(LANES)) u_classify (
    .live_mask (active_mask),
    .taken_raw (br_taken_mask),
    .taken_live(taken_live),
    .fall_live (fall_live),
    .kind      (kind)
  );

  assign br_ready    = !reconv_hit;
  assign br_fire     = br_valid && br_ready;
  assign stack_empty = (fill == '0);
  assign do_pop      = reconv_hit && !stack_empty;
  assign has_room    = (fill <= CNT_W'(DEPTH - 2));
  assign do_push     = br_fire && (kind == BR_SPLIT) && has_room;
  assign refuse      = br_fire && (kind == BR_SPLIT) && !has_room;

  simt_entry_lifo #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_lifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push2   (do_push),
    .pop     (do_pop),
    .lo_pc   (br_reconv),
    .lo_mask (active_mask),
    .hi_pc   (br_fallthru),
    .hi_mask (fall_live),
    .top_pc  (top_pc),
    .top_mask(top_mask),
    .fill    (fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pc         <= RESET_PC;
      active_mask    <= '1;
      stack_overflow <= 1'b0;
    end else begin
      stack_overflow <= stack_overflow || refuse;
      if (do_pop) begin
        cur_pc      <= top_pc;
        active_mask <= top_mask;
      end else if (br_fire) begin
        unique case (kind)
          BR_ALL_TAKEN: cur_pc <= br_target;
          BR_ALL_FALL:  cur_pc <= br_fallthru;
          default: if (has_room) begin
            cur_pc      <= br_target;
            active_mask <= taken_live;
          end
        endcase
      end
    end
  end

  AST_TAKEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (cur_pc == $past(br_target)) &&
                (active_mask == ($past(active_mask) & $past(br_taken_mask)))); // R5
  AST_UNIFORM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fire && kind != BR_SPLIT) |=> $stable(active_mask) && $stable(fill)); // R2
  AST_REFUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> $stable(cur_pc) && $stable(active_mask) && stack_overflow); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_overflow |=> stack_overflow); // R9
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reconv_hit && stack_empty) |=> $stable(cur_pc) && $stable(active_mask)); // R10
  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0); // R4
endmodule

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int PC_W  = 8;
  localparam int DEPTH = 4;
  localparam logic [7:0] RST_PC = 8'h40;

  logic clk = 0, rst_n = 0;
  logic br_valid = 0, reconv_hit = 0, br_ready;
  logic [3:0] br_taken_mask = '0;
  logic [7:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic [7:0] cur_pc;
  logic [3:0] active_mask;
  logic stack_empty, stack_overflow;

  int checks = 0, errors = 0;
  logic [7:0] m_pc; logic [3:0] m_mask; int m_cnt; logic m_ovf;
  logic [7:0] s_pc [DEPTH]; logic [3:0] s_mask [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_taken_mask(br_taken_mask), .br_target(br_target), .br_fallthru(br_fallthru),
    .br_reconv(br_reconv), .reconv_hit(reconv_hit), .cur_pc(cur_pc),
    .active_mask(active_mask), .stack_empty(stack_empty), .stack_overflow(stack_overflow));

  task automatic check(input string req);
    checks++;
    if (cur_pc !== m_pc || active_mask !== m_mask ||
        stack_empty !== (m_cnt == 0) || stack_overflow !== m_ovf) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%b empty=%b ovf=%b, expected pc=%h mask=%b empty=%b ovf=%b",
               req, cur_pc, active_mask, stack_empty, stack_overflow,
               m_pc, m_mask, (m_cnt == 0), m_ovf);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    m_pc = RST_PC; m_mask = 4'hF; m_cnt = 0; m_ovf = 0;
  endtask

  // Expected effect of an accepted branch, from R2/R3/R5/R9.
  task automatic model_branch(input logic [3:0] t, input logic [7:0] tg, ft, rc);
    logic [3:0] on, off;
    on = m_mask & t; off = m_mask & ~t;
    if (on == 0) m_pc = ft;
    else if (off == 0) m_pc = tg;
    else if (m_cnt > DEPTH - 2) m_ovf = 1;
    else begin
      s_pc[m_cnt] = rc; s_mask[m_cnt] = m_mask;
      s_pc[m_cnt+1] = ft; s_mask[m_cnt+1] = off;
      m_cnt += 2; m_pc = tg; m_mask = on;
    end
  endtask

  task automatic model_pop();
    if (m_cnt > 0) begin
      m_cnt--; m_pc = s_pc[m_cnt]; m_mask = s_mask[m_cnt];
    end
  endtask

  task automatic branch(input logic [3:0] t, input logic [7:0] tg, ft, rc, input string req);
    br_valid = 1; br_taken_mask = t; br_target = tg; br_fallthru = ft; br_reconv = rc;
    @(negedge clk);
    br_valid = 0;
    model_branch(t, tg, ft, rc);
    check(req);
  endtask

  task automatic pop(input string req);
    reconv_hit = 1;
    @(negedge clk);
    reconv_hit = 0;
    model_pop();
    check(req);
  endtask

  function automatic string kind_tag(input logic [3:0] t, input string split_tag);
    logic [3:0] on, off;
    on = m_mask & t; off = m_mask & ~t;
    if (on == 0) return "R3";
    if (off == 0) return "R2";
    return split_tag;
  endfunction

  task automatic unwind_to(input int base);
    while (m_cnt > base) pop((m_cnt % 2 == 0) ? "R6" : "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1");

    // Single-level sweep of every taken pattern from the full mask.
    for (int t = 0; t < 16; t++) begin
      string tag;
      tag = kind_tag(4'(t), "R5");
      branch(4'(t), 8'h80 | 8'(t), 8'h20 | 8'(t), 8'h60 | 8'(t), tag);
      unwind_to(0);
    end

    // Empty-stack pop does nothing (R10, R12).
    pop("R10");

    // Nested sweep: inner lanes outside the outer taken set are inactive.
    for (int a = 1; a < 15; a++) begin
      for (int b = 0; b < 16; b++) begin
        string tag;
        branch(4'(a), 8'hA0 | 8'(a), 8'h30 | 8'(a), 8'h70 | 8'(a), "R5");
        if ((4'(b) & ~m_mask) != 0) tag = kind_tag(4'(b), "R8");
        else tag = kind_tag(4'(b), "R8");
        if ((m_mask & 4'(b)) == 0 || (m_mask & ~4'(b)) == 0)
          tag = ((4'(b) & ~m_mask) != 0) ? "R4" : tag;
        branch(4'(b), 8'hC0 | 8'(b), 8'h10 | 8'(b), 8'h50 | 8'(b), tag);
        while (m_cnt > 0) pop("R8");
      end
    end

    // Collision of branch and pop: ready drops, only the pop happens (R11).
    branch(4'b0101, 8'h91, 8'h92, 8'h93, "R5");
    br_valid = 1; br_taken_mask = 4'b0001; br_target = 8'hEE; br_fallthru = 8'hEF;
    br_reconv = 8'hED; reconv_hit = 1;
    #1;
    checks++;
    if (br_ready !== 1'b0) begin
      errors++;
      $display("FAIL R11: br_ready=%b, expected 0", br_ready);
    end
    @(negedge clk);
    br_valid = 0; reconv_hit = 0;
    model_pop();
    check("R11");
    unwind_to(0);

    // Overflow: fill the stack, then one more divergence is refused (R9).
    do_reset();
    check("R1");
    branch(4'b0111, 8'hB1, 8'hB2, 8'hB3, "R5");
    branch(4'b0011, 8'hC1, 8'hC2, 8'hC3, "R5");
    branch(4'b0001, 8'hD1, 8'hD2, 8'hD3, "R9");
    branch(4'b0011, 8'hE1, 8'hE2, 8'hE3, "R2");
    while (m_cnt > 0) pop("R9");
    pop("R10");
    do_reset();
    check("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule